// File: doc/BRIEF.md
# Interrupt Router with Status, Enable and Acknowledge Registers

This block gathers the interrupt sources of a host-I/O peripheral and a video frame-sync generator and drives a CPU's two request lines. Completion pulses from the peripheral and, when so routed, the frame-sync pulse set sticky bits in a status register. A level interrupt request (`irq`) is raised while any set status bit is also enabled. Software clears bits by writing a mask of ones to an acknowledge register. All three registers sit in a 32-byte byte-wide register window.

A two-bit strap selects where the frame-sync pulse goes: nowhere, into the maskable status path, or straight to a non-maskable request (`nmi`) that pulses for one cycle per frame. The strap is captured only while reset is held, so a running program cannot change the routing.

Top module: `irq_route_regs`

## Requirements
- R1: While and after reset, the status register (offset 0x11) and the enable register (offset 0x12) read 0, and `irq` and `nmi` are low.
- R2: A completion pulse sets status bit 0 at the next clock edge. The bit stays set until it is acknowledged.
- R3: The enable register at offset 0x12 stores the low two bits of a write (bit 0 for completion, bit 1 for frame-sync). Its upper bits read 0.
- R4: `irq` is high in exactly the cycles where some status bit and the matching enable bit are both 1.
- R5: A write to offset 0x13 clears every status bit whose position holds a 1 in the written byte. Bits written as 0 are untouched.
- R6: When a write to offset 0x13 lands in the same cycle as an event that sets a bit, the bit ends up set.
- R7: With strap value 2'b01 (maskable routing), a frame-sync pulse sets status bit 1 and never pulses `nmi`.
- R8: With strap value 2'b10 (non-maskable routing), each cycle of frame-sync pulse gives `nmi` high for the following cycle, whatever the enable register holds. Status bit 1 stays clear.
- R9: With strap value 2'b00 (the default) or 2'b11, a frame-sync pulse changes neither status nor `nmi`.
- R10: The strap is captured only while `rst_n` is low. Changing it after reset has no effect on routing.
- R11: Writes to the status offset and to unmapped offsets change no register. Reads of the acknowledge offset and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the window in which the strap is captured |
| route_strap | input | 2 | Frame-sync routing: 00 off, 01 maskable, 10 non-maskable, 11 off |
| bus_sel | input | 1 | Register window access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the 32-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read |
| done_pulse | input | 1 | Completion event from the host-I/O peripheral |
| sync_pulse | input | 1 | Frame-sync event |
| irq | output | 1 | Maskable interrupt request, level |
| nmi | output | 1 | Non-maskable interrupt request, one-cycle pulse |

## Verification
The status path is driven with single completion pulses, frame-sync pulses, and both together. Enable patterns of none, one bit and both bits show that `irq` follows the masked status rather than the raw status. Acknowledge writes with the wrong bit, the right bit and all bits separate a per-bit clear from a clear-all, and an acknowledge that coincides with a completion pulse shows which side wins. The same frame-sync stimulus is repeated under each of the four strap codes, and once with a strap change that has no reset, to tell routing chosen at reset from routing that follows the live pins.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    ROUTE_OFF  = 2'b00,
    ROUTE_IRQ  = 2'b01,
    ROUTE_NMI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  // Reserved strap code falls back to "off".
  function automatic route_e route_decode(input logic [1:0] strap);
    case (strap)
      2'b01:   return ROUTE_IRQ;
      2'b10:   return ROUTE_NMI;
      default: return ROUTE_OFF;
    endcase
  endfunction

  // Next value of one sticky status bit: a set beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_route_latch.sv
module irq_route_latch
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] route_strap,
  output route_e     route
);

  route_e route_q;

  // Loaded on every clock edge while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) route_q <= route_decode(route_strap);
  end

  assign route = route_q;

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int ADDR_W   = 5,
  parameter int STAT_OFS = 'h11,
  parameter int EN_OFS   = 'h12,
  parameter int ACK_OFS  = 'h13
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              stat_wr_hit,
  output logic              en_wr_hit,
  output logic              ack_wr_hit,
  output logic              stat_rd_hit,
  output logic              en_rd_hit
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

  logic is_wr, is_rd;

  always_comb begin
    is_wr       = bus_sel &  bus_wr;
    is_rd       = bus_sel & ~bus_wr;
    stat_wr_hit = is_wr & (bus_addr == STAT_A);
    en_wr_hit   = is_wr & (bus_addr == EN_A);
    ack_wr_hit  = is_wr & (bus_addr == ACK_A);
    stat_rd_hit = is_rd & (bus_addr == STAT_A);
    en_rd_hit   = is_rd & (bus_addr == EN_A);
  end

endmodule

// File: rtl/irq_sync_router.sv
module irq_sync_router
  import irq_route_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   sync_pulse,
  output logic   sync_to_irq,
  output logic   sync_to_nmi,
  output logic   nmi
);

  logic nmi_q;

  always_comb begin
    sync_to_irq = sync_pulse & (route == ROUTE_IRQ);
    sync_to_nmi = sync_pulse & (route == ROUTE_NMI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= sync_to_nmi;
  end

  assign nmi = nmi_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_route_pkg::*;
#(
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              ack_wr,
  input  logic [STAT_W-1:0] ack_mask,
  input  logic              en_wr,
  input  logic [STAT_W-1:0] en_data,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] en_q,
  output logic              irq
);

  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] live_vec;

  assign clr_vec = ack_wr ? ack_mask : '0;

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[gi] <= 1'b0;
        else        stat_q[gi] <= sticky_next(stat_q[gi], set_vec[gi], clr_vec[gi]);
      end
      assign live_vec[gi] = stat_q[gi] & en_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_data;
  end

  assign irq = |live_vec;

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int WIN_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int N_DONE    = 1,
  parameter int STAT_OFS  = 'h11,
  parameter int EN_OFS    = 'h12,
  parameter int ACK_OFS   = 'h13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   route_strap,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [$clog2(WIN_BYTES)-1:0] bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [N_DONE-1:0]            done_pulse,
  input  logic                         sync_pulse,
  output logic                         irq,
  output logic                         nmi
);

  localparam int ADDR_W   = $clog2(WIN_BYTES);
  localparam int STAT_W   = N_DONE + 1;
  localparam int SYNC_BIT = N_DONE;

  // Named internal events, also used by the bound checker.
  route_e            route;
  logic              stat_wr_hit, en_wr_hit, ack_wr_hit;
  logic              stat_rd_hit, en_rd_hit;
  logic              sync_to_irq, sync_to_nmi;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] wr_bits;
  logic [STAT_W-1:0] stat_q, en_q;

  assign wr_bits = STAT_W'(bus_wdata);

  irq_route_latch u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .route_strap (route_strap),
    .route       (route)
  );

  irq_bus_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS),
    .ACK_OFS  (ACK_OFS)
  ) u_dec (
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .stat_wr_hit (stat_wr_hit),
    .en_wr_hit   (en_wr_hit),
    .ack_wr_hit  (ack_wr_hit),
    .stat_rd_hit (stat_rd_hit),
    .en_rd_hit   (en_rd_hit)
  );

  irq_sync_router u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .route       (route),
    .sync_pulse  (sync_pulse),
    .sync_to_irq (sync_to_irq),
    .sync_to_nmi (sync_to_nmi),
    .nmi         (nmi)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[N_DONE-1:0] = done_pulse;
    set_vec[SYNC_BIT] = sync_to_irq;
  end

  irq_status_bank #(.STAT_W(STAT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .ack_wr   (ack_wr_hit),
    .ack_mask (wr_bits),
    .en_wr    (en_wr_hit),
    .en_data  (wr_bits),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .irq      (irq)
  );

  always_comb begin
    if (stat_rd_hit)    bus_rdata = DATA_W'(stat_q);
    else if (en_rd_hit) bus_rdata = DATA_W'(en_q);
    else                bus_rdata = '0;
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int N_DONE = 1,
  parameter int STAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_DONE-1:0] done_pulse,
  input logic              sync_pulse,
  input logic              ack_wr_hit,
  input logic              en_wr_hit,
  input logic              stat_wr_hit,
  input logic [STAT_W-1:0] wr_bits,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q,
  input route_e            route,
  input logic              irq,
  input logic              nmi
);

  assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse[0] |=> stat_q[0]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !ack_wr_hit) |=> stat_q[0]);

  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse[0] && en_q[0] && !en_wr_hit) |=> irq);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_hit && wr_bits[0] && !done_pulse[0]) |=> !stat_q[0]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_hit && done_pulse[0]) |=> stat_q[0]);

  assert_sync_to_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && route == ROUTE_IRQ) |=> stat_q[STAT_W-1]);

  assert_nmi_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && route == ROUTE_NMI) |=> nmi);

  assert_nmi_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(sync_pulse));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_OFF) |-> !nmi);

  assert_route_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(route));

  assert_status_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_hit && done_pulse == '0 && !sync_pulse) |=> $stable(stat_q));

endmodule

bind irq_route_regs irq_route_chk #(.N_DONE(N_DONE), .STAT_W(STAT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_pulse  (done_pulse),
  .sync_pulse  (sync_pulse),
  .ack_wr_hit  (ack_wr_hit),
  .en_wr_hit   (en_wr_hit),
  .stat_wr_hit (stat_wr_hit),
  .wr_bits     (wr_bits),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .route       (route),
  .irq         (irq),
  .nmi         (nmi)
);

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] route_strap = 2'b00;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [0:0] done_pulse = 1'b0;
  logic       sync_pulse = 1'b0;
  logic       irq, nmi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    bit         chk_rd;
    logic [7:0] rd;
    logic       irq;
    logic       nmi;
  } exp_t;

  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  irq_route_regs dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .route_strap (route_strap),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .done_pulse  (done_pulse),
    .sync_pulse  (sync_pulse),
    .irq         (irq),
    .nmi         (nmi)
  );

  // Monitor: compares at the falling edge, between driver updates.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (e.chk_rd && bus_rdata !== e.rd) begin
        bad++;
        $display("FAIL %s rdata actual=%02h expected=%02h", e.tag, bus_rdata, e.rd);
      end else if (irq !== e.irq) begin
        bad++;
        $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq);
      end else if (nmi !== e.nmi) begin
        bad++;
        $display("FAIL %s nmi actual=%b expected=%b", e.tag, nmi, e.nmi);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag, input bit chk_rd, input logic [7:0] rd,
                      input logic e_irq, input logic e_nmi);
    exp_t e;
    e.tag = tag; e.chk_rd = chk_rd; e.rd = rd; e.irq = e_irq; e.nmi = e_nmi;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst_n = 1'b0;
    route_strap = strap;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp_rd,
                        input logic e_irq, input logic e_nmi);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    push(tag, 1'b1, exp_rd, e_irq, e_nmi);
    tick();
    bus_sel = 1'b0;
  endtask

  task automatic pulse_done();
    done_pulse = 1'b1;
    tick();
    done_pulse = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_pulse = 1'b1;
    tick();
    sync_pulse = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, maskable routing
    do_reset(2'b01);
    rd_chk("R1 status", 5'h11, 8'h00, 1'b0, 1'b0);
    rd_chk("R1 enable", 5'h12, 8'h00, 1'b0, 1'b0);

    // R3: enable keeps two bits only
    wr(5'h12, 8'hFF);
    rd_chk("R3 enable all", 5'h12, 8'h03, 1'b0, 1'b0);
    wr(5'h12, 8'h00);
    rd_chk("R3 enable clear", 5'h12, 8'h00, 1'b0, 1'b0);

    // R2: completion sets bit 0, sticky; R4: masked so irq low
    pulse_done();
    rd_chk("R2 set", 5'h11, 8'h01, 1'b0, 1'b0);
    rd_chk("R2 sticky", 5'h11, 8'h01, 1'b0, 1'b0);

    // R4: enabling raises irq
    wr(5'h12, 8'h01);
    rd_chk("R4 raise", 5'h11, 8'h01, 1'b1, 1'b0);

    // R5: wrong-bit ack keeps, right-bit ack clears
    wr(5'h13, 8'h02);
    rd_chk("R5 other bit", 5'h11, 8'h01, 1'b1, 1'b0);
    wr(5'h13, 8'h01);
    rd_chk("R5 cleared", 5'h11, 8'h00, 1'b0, 1'b0);

    // R7: frame-sync into status bit 1, masked until enabled
    pulse_sync();
    rd_chk("R7 set", 5'h11, 8'h02, 1'b0, 1'b0);
    wr(5'h12, 8'h03);
    rd_chk("R7 enabled", 5'h11, 8'h02, 1'b1, 1'b0);

    // R6: ack all while completion pulses
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h13; bus_wdata = 8'h03;
    done_pulse = 1'b1;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; done_pulse = 1'b0;
    rd_chk("R6 event wins", 5'h11, 8'h01, 1'b1, 1'b0);

    // R11: writes to status / unmapped offsets, reads of ack / unmapped
    wr(5'h11, 8'h00);
    rd_chk("R11 status ro", 5'h11, 8'h01, 1'b1, 1'b0);
    wr(5'h05, 8'hFF);
    rd_chk("R11 enable kept", 5'h12, 8'h03, 1'b1, 1'b0);
    rd_chk("R11 unmapped read", 5'h05, 8'h00, 1'b1, 1'b0);
    rd_chk("R11 ack read", 5'h13, 8'h00, 1'b1, 1'b0);

    // R10: strap change without reset is ignored
    route_strap = 2'b10;
    pulse_sync();
    rd_chk("R10 still maskable", 5'h11, 8'h03, 1'b1, 1'b0);
    wr(5'h13, 8'h03);
    rd_chk("R4 drop", 5'h11, 8'h00, 1'b0, 1'b0);

    // R8: non-maskable routing
    do_reset(2'b10);
    rd_chk("R1 status after reset", 5'h11, 8'h00, 1'b0, 1'b0);
    wr(5'h12, 8'h03);
    pulse_sync();
    rd_chk("R8 nmi pulse", 5'h11, 8'h00, 1'b0, 1'b1);
    rd_chk("R8 nmi one cycle", 5'h11, 8'h00, 1'b0, 1'b0);
    sync_pulse = 1'b1;
    tick();
    push("R8 back-to-back first", 1'b0, 8'h00, 1'b0, 1'b1);
    tick();
    sync_pulse = 1'b0;
    push("R8 back-to-back second", 1'b0, 8'h00, 1'b0, 1'b1);
    tick();
    push("R8 back-to-back end", 1'b0, 8'h00, 1'b0, 1'b0);
    tick();

    // R9: routing off, codes 00 and 11
    do_reset(2'b00);
    wr(5'h12, 8'h03);
    pulse_sync();
    rd_chk("R9 off code 00", 5'h11, 8'h00, 1'b0, 1'b0);
    do_reset(2'b11);
    wr(5'h12, 8'h03);
    pulse_sync();
    rd_chk("R9 off code 11", 5'h11, 8'h00, 1'b0, 1'b0);

    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule